// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block brings a DRAM with an internal row counter out of power-up and then keeps it refreshed. After reset it stays silent for a power-up delay. It then asks the access controller for the memory bus and runs a burst of initialisation refresh cycles. When that burst is finished it raises a ready flag. The access controller must not accept host traffic while the flag is low.

In normal service, an interval counter marks each point at which one refresh falls due. Each due refresh is added to an owed count, which stops rising at a ceiling. While anything is owed, the block holds a bus request. Once the controller grants the bus, the block drives the row and column strobes itself. It runs column-before-row refresh cycles back to back until nothing is owed. Because the row counter is internal, no address is driven. The data pins must float while a cycle is in flight.

Every timing value is a parameter in clock cycles. The defaults suit a 50 MHz clock.

Top module: `dref_seq`

## Requirements
- R1: During and directly after reset, `ref_req` is 0, `ras_n` and `cas_n` are 1, `mem_ready` is 0, `dq_float` is 0 and `owed_cnt` is 0.
- R2: `ref_req` stays 0 for the first PWRUP_CYC-1 rising edges after reset is released, and is 1 after edge PWRUP_CYC.
- R3: Exactly INIT_CNT refresh cycles run before `mem_ready` rises. `mem_ready` then stays 1 until reset.
- R4: In each refresh cycle, `cas_n` goes low CSR_CYC cycles before `ras_n` falls and stays low for CHR_CYC cycles with `ras_n` low. `ras_n` is low for exactly RAS_LOW_CYC cycles. Both strobes are then high for at least max(RP_CYC, RPC_CYC) cycles before `cas_n` falls again.
- R5: Once `mem_ready` is 1, one refresh falls due every INTERVAL_CYC cycles, the first at edge INTERVAL_CYC after `mem_ready` rises. Each due refresh raises `owed_cnt` (unsigned binary) by one, and `owed_cnt` never moves by more than one per cycle.
- R6: `owed_cnt` saturates at PEND_MAX (default 8) when due refreshes go ungranted.
- R7: Each completed refresh in service lowers `owed_cnt` by one. While the grant stays high, cycles run back to back until `owed_cnt` is 0. Then `ref_req` falls.
- R8: When a refresh falls due in the same cycle that one completes, `owed_cnt` is unchanged. This includes the case where `owed_cnt` is at PEND_MAX.
- R9: `ras_n` and `cas_n` are 1 whenever `ref_gnt` is 0. If the grant is withdrawn mid-cycle, the cycle is abandoned, `owed_cnt` is not lowered and `ref_req` stays high.
- R10: When `ref_req` is 0, both strobes are 1. `ref_req` only falls after both strobes have been high for a full cycle.
- R11: `dq_float` is 1 whenever either strobe is low, and 0 when the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt | input | 1 | Bus grant from the access controller |
| ref_req | output | 1 | Bus request to the access controller |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| dq_float | output | 1 | Data pins must be high-impedance |
| mem_ready | output | 1 | Initialisation complete |
| owed_cnt | output | clog2(PEND_MAX+1) | Refreshes still owed |

## Verification
A due refresh and the completion of a granted refresh can meet on the same clock edge. At that edge, the owed count is pushed up and pulled down at once. The bench aligns itself to a due-refresh edge by watching the owed count step. It then raises the grant exactly one cycle-length plus one cycle before the next due edge, so that the completing precharge lands on that edge. It then checks that the count is unchanged, once at a count of one and once at the ceiling, and that the expected total number of row pulses follows.

// File: rtl/dref_pkg.sv
package dref_pkg;

    typedef enum logic [2:0] {
        CY_IDLE,
        CY_SETUP,
        CY_HOLD,
        CY_RLOW,
        CY_PRE
    } cyc_state_t;

    typedef enum logic [1:0] {
        PH_WAIT,
        PH_INIT,
        PH_RUN
    } phase_t;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
    } strobe_t;

    function automatic int unsigned imax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned cnt_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    function automatic strobe_t stb_of(input cyc_state_t s);
        strobe_t r;
        case (s)
            CY_SETUP: r = '{ras_n: 1'b1, cas_n: 1'b0};
            CY_HOLD:  r = '{ras_n: 1'b0, cas_n: 1'b0};
            CY_RLOW:  r = '{ras_n: 1'b0, cas_n: 1'b1};
            default:  r = '{ras_n: 1'b1, cas_n: 1'b1};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dref_tick.sv
module dref_tick
    import dref_pkg::*;
#(
    parameter int unsigned PERIOD = 780
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int unsigned W = cnt_w(PERIOD);

    logic [W-1:0] cnt;

    assign tick = en && (cnt == W'(PERIOD - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= tick ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/dref_owe.sv
module dref_owe #(
    parameter int unsigned MAX = 8,
    parameter int unsigned W   = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] cnt
);
    logic up, dn;

    assign dn = dec && (cnt != '0);
    assign up = inc && ((cnt != W'(MAX)) || dn);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            case ({up, dn})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/dref_cyc.sv
module dref_cyc
    import dref_pkg::*;
#(
    parameter int unsigned CSR  = 1,
    parameter int unsigned CHR  = 1,
    parameter int unsigned RLOW = 3,
    parameter int unsigned PRE  = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    owe,
    input  logic    gnt,
    output strobe_t stb,
    output logic    busy,
    output logic    done
);
    localparam int unsigned RLO = RLOW - CHR;
    localparam int unsigned TW  = cnt_w(imax(imax(CSR, CHR), imax(RLO, PRE)));

    cyc_state_t    state;
    logic [TW-1:0] tcnt;
    logic          aborted;

    assign stb  = stb_of(state);
    assign busy = (state != CY_IDLE);
    assign done = (state == CY_PRE) && (tcnt == '0) && !aborted;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= CY_IDLE;
            tcnt    <= '0;
            aborted <= 1'b0;
        end else begin
            case (state)
                CY_IDLE: begin
                    if (owe && gnt) begin
                        state   <= CY_SETUP;
                        tcnt    <= TW'(CSR - 1);
                        aborted <= 1'b0;
                    end
                end
                CY_SETUP: begin
                    if (!gnt) begin
                        state   <= CY_PRE;
                        tcnt    <= TW'(PRE - 1);
                        aborted <= 1'b1;
                    end else if (tcnt == '0) begin
                        state <= CY_HOLD;
                        tcnt  <= TW'(CHR - 1);
                    end else begin
                        tcnt <= tcnt - 1'b1;
                    end
                end
                CY_HOLD: begin
                    if (!gnt) begin
                        state   <= CY_PRE;
                        tcnt    <= TW'(PRE - 1);
                        aborted <= 1'b1;
                    end else if (tcnt == '0) begin
                        state <= CY_RLOW;
                        tcnt  <= TW'(RLO - 1);
                    end else begin
                        tcnt <= tcnt - 1'b1;
                    end
                end
                CY_RLOW: begin
                    if (!gnt) begin
                        state   <= CY_PRE;
                        tcnt    <= TW'(PRE - 1);
                        aborted <= 1'b1;
                    end else if (tcnt == '0) begin
                        state <= CY_PRE;
                        tcnt  <= TW'(PRE - 1);
                    end else begin
                        tcnt <= tcnt - 1'b1;
                    end
                end
                CY_PRE: begin
                    if (tcnt == '0) begin
                        state <= CY_IDLE;
                    end else begin
                        tcnt <= tcnt - 1'b1;
                    end
                end
                default: state <= CY_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dref_seq.sv
module dref_seq
    import dref_pkg::*;
#(
    parameter int unsigned PWRUP_CYC    = 10000,
    parameter int unsigned INIT_CNT     = 8,
    parameter int unsigned INTERVAL_CYC = 780,
    parameter int unsigned CSR_CYC      = 1,
    parameter int unsigned CHR_CYC      = 1,
    parameter int unsigned RAS_LOW_CYC  = 3,
    parameter int unsigned RP_CYC       = 2,
    parameter int unsigned RPC_CYC      = 1,
    parameter int unsigned PEND_MAX     = 8,
    localparam int unsigned OW          = cnt_w(PEND_MAX)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ref_gnt,
    output logic          ref_req,
    output logic          ras_n,
    output logic          cas_n,
    output logic          dq_float,
    output logic          mem_ready,
    output logic [OW-1:0] owed_cnt
);
    localparam int unsigned IW      = cnt_w(INIT_CNT);
    localparam int unsigned PRE_CYC = imax(RP_CYC, RPC_CYC);

    phase_t        phase;
    logic [IW-1:0] init_left;
    logic          pwr_tick, ivl_tick;
    logic          owe, busy, done;
    strobe_t       stb;

    dref_tick #(.PERIOD(PWRUP_CYC)) u_pwr (
        .clk (clk),
        .rst (rst),
        .en  (phase == PH_WAIT),
        .tick(pwr_tick)
    );

    dref_tick #(.PERIOD(INTERVAL_CYC)) u_ivl (
        .clk (clk),
        .rst (rst),
        .en  (phase == PH_RUN),
        .tick(ivl_tick)
    );

    dref_owe #(.MAX(PEND_MAX), .W(OW)) u_owe (
        .clk(clk),
        .rst(rst),
        .inc(ivl_tick),
        .dec(done && (phase == PH_RUN)),
        .cnt(owed_cnt)
    );

    dref_cyc #(
        .CSR (CSR_CYC),
        .CHR (CHR_CYC),
        .RLOW(RAS_LOW_CYC),
        .PRE (PRE_CYC)
    ) u_cyc (
        .clk (clk),
        .rst (rst),
        .owe (owe),
        .gnt (ref_gnt),
        .stb (stb),
        .busy(busy),
        .done(done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_WAIT;
            init_left <= IW'(INIT_CNT);
        end else begin
            case (phase)
                PH_WAIT: if (pwr_tick) phase <= PH_INIT;
                PH_INIT: begin
                    if (done) begin
                        init_left <= init_left - 1'b1;
                        if (init_left == IW'(1)) phase <= PH_RUN;
                    end
                end
                default: phase <= PH_RUN;
            endcase
        end
    end

    assign owe       = (phase == PH_INIT) || ((phase == PH_RUN) && (owed_cnt != '0));
    assign ref_req   = busy || owe;
    assign ras_n     = stb.ras_n | ~ref_gnt;
    assign cas_n     = stb.cas_n | ~ref_gnt;
    assign dq_float  = busy;
    assign mem_ready = (phase == PH_RUN);
endmodule

// File: rtl/dref_seq_chk.sv
module dref_seq_chk #(
    parameter int unsigned PEND_MAX = 8,
    parameter int unsigned OW       = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          ref_req,
    input logic          ras_n,
    input logic          cas_n,
    input logic          dq_float,
    input logic          mem_ready,
    input logic [OW-1:0] owed_cnt
);
    p_cbr_order_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

    p_pre_high_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |=> (ras_n && cas_n));

    p_owed_step_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(owed_cnt) |-> ((owed_cnt == $past(owed_cnt) + 1'b1) ||
                                (owed_cnt == $past(owed_cnt) - 1'b1)));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        owed_cnt <= OW'(PEND_MAX));

    p_ready_keep_r3: assert property (@(posedge clk) disable iff (rst)
        mem_ready |=> mem_ready);

    p_release_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(ref_req) |-> (ras_n && cas_n && $past(ras_n) && $past(cas_n)));

    p_float_r11: assert property (@(posedge clk) disable iff (rst)
        (!ras_n || !cas_n) |-> dq_float);
endmodule

bind dref_seq dref_seq_chk #(.PEND_MAX(PEND_MAX), .OW(OW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ref_req  (ref_req),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .dq_float (dq_float),
    .mem_ready(mem_ready),
    .owed_cnt (owed_cnt)
);

// File: tb/sim_dref_seq.sv
`timescale 1ns/1ps
module sim_dref_seq;
    localparam int PWR  = 10000;
    localparam int INIT = 8;
    localparam int IVL  = 780;
    localparam int CSR  = 1;
    localparam int CHR  = 1;
    localparam int RLOW = 3;
    localparam int RP   = 2;
    localparam int RPC  = 1;
    localparam int PMAX = 8;
    localparam int PRE  = (RP > RPC) ? RP : RPC;
    localparam int LEN  = CSR + RLOW + PRE;
    localparam int WD_CYC = 150000;

    localparam int VEC_N = 5;
    localparam int VEC_TICKS [VEC_N] = '{1, 2, 8, 9, 12};
    localparam int VEC_EXP   [VEC_N] = '{1, 2, 8, 8, 8};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_gnt = 1'b0;
    logic ref_req, ras_n, cas_n, dq_float, mem_ready;
    logic [3:0] owed_cnt;

    int n_chk = 0;
    int n_fail = 0;
    int pulse_cnt = 0;
    int v_gnt = 0, v_req = 0, v_flt = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dref_seq #(
        .PWRUP_CYC(PWR), .INIT_CNT(INIT), .INTERVAL_CYC(IVL),
        .CSR_CYC(CSR), .CHR_CYC(CHR), .RAS_LOW_CYC(RLOW),
        .RP_CYC(RP), .RPC_CYC(RPC), .PEND_MAX(PMAX)
    ) u0 (
        .clk(clk), .rst(rst), .ref_gnt(ref_gnt), .ref_req(ref_req),
        .ras_n(ras_n), .cas_n(cas_n), .dq_float(dq_float),
        .mem_ready(mem_ready), .owed_cnt(owed_cnt)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #2;
        end
    endtask

    // strobe monitor: samples 4 ns after each falling edge
    initial begin
        int lead = 0, low_len = 0, hold_len = 0, gap = 1000;
        bit pr = 1'b1, pc = 1'b1, seen = 1'b0;
        forever begin
            @(negedge clk);
            #4;
            if (!rst) begin
                if (pr && !ras_n) begin
                    chk(!cas_n && !pc && lead == CSR, "R4 cas lead before ras fall", lead, CSR);
                    pulse_cnt++;
                    low_len = 1;
                    hold_len = 1;
                    lead = 0;
                end else if (!ras_n) begin
                    low_len++;
                    if (!cas_n) hold_len++;
                end
                if (!pr && ras_n) begin
                    chk(low_len == RLOW, "R4 ras low width", low_len, RLOW);
                    chk(hold_len == CHR, "R4 cas hold after ras fall", hold_len, CHR);
                    gap = 0;
                    seen = 1'b1;
                end
                if (!pc && cas_n && ras_n) gap = 0;
                if (ras_n && cas_n) gap++;
                if (pc && !cas_n && ras_n) begin
                    if (seen) chk(gap >= PRE, "R4 precharge before next cycle", gap, PRE);
                end
                if (!cas_n && ras_n) lead++;
                else if (cas_n) lead = 0;
                if (!ref_gnt && !(ras_n && cas_n)) v_gnt++;
                if (!ref_req && !(ras_n && cas_n)) v_req++;
                if ((!ras_n || !cas_n) && !dq_float) v_flt++;
                pr = ras_n;
                pc = cas_n;
            end
        end
    end

    task automatic drain(input int exp, input string tag);
        int p0;
        int g;
        p0 = pulse_cnt;
        g = 0;
        ref_gnt = 1'b1;
        while (g < 2000) begin
            step(1);
            g++;
            if (!ref_req) break;
        end
        ref_gnt = 1'b0;
        #3;
        chk(pulse_cnt - p0 == exp, tag, pulse_cnt - p0, exp);
        chk(owed_cnt == 0, "R7 owed empty after drain", int'(owed_cnt), 0);
        chk(!dq_float, "R11 float low when idle", int'(dq_float), 0);
    endtask

    task automatic align();
        int g;
        g = 0;
        while (owed_cnt == 0 && g < 2 * IVL) begin
            step(1);
            g++;
        end
        chk(owed_cnt == 1, "R5 due refresh seen", int'(owed_cnt), 1);
    endtask

    initial begin
        int p0;
        int g;
        step(3);
        chk(!ref_req && ras_n && cas_n && !mem_ready && !dq_float && owed_cnt == 0,
            "R1 reset state", {ref_req, ras_n, cas_n, mem_ready, dq_float}, 5'b01100);
        rst = 1'b0;
        step(PWR - 1);
        chk(!ref_req, "R2 no request during power-up", int'(ref_req), 0);
        step(1);
        chk(ref_req, "R2 request after power-up", int'(ref_req), 1);
        chk(ras_n && cas_n, "R9 strobes high without grant", {ras_n, cas_n}, 2'b11);
        chk(pulse_cnt == 0, "R3 no cycle before grant", pulse_cnt, 0);

        ref_gnt = 1'b1;
        g = 0;
        while (!mem_ready && g < 2000) begin
            step(1);
            g++;
        end
        chk(pulse_cnt == INIT, "R3 init cycle count", pulse_cnt, INIT);
        chk(!ref_req, "R7 request drops after init", int'(ref_req), 0);
        ref_gnt = 1'b0;

        step(IVL - 1);
        chk(owed_cnt == 0 && mem_ready, "R5 nothing owed before interval", int'(owed_cnt), 0);
        step(1);
        chk(owed_cnt == 1, "R5 first due refresh", int'(owed_cnt), 1);
        drain(1, "R7 single refresh serviced");

        for (int v = 0; v < VEC_N; v++) begin
            align();
            step((VEC_TICKS[v] - 1) * IVL);
            chk(owed_cnt == VEC_EXP[v], "R6 owed count after ungranted intervals",
                int'(owed_cnt), VEC_EXP[v]);
            drain(VEC_EXP[v], "R7 back-to-back drain pulses");
        end

        // R8 collision at a count of one
        align();
        p0 = pulse_cnt;
        step(IVL - LEN - 1);
        ref_gnt = 1'b1;
        step(LEN + 1);
        chk(owed_cnt == 1, "R8 due and done same cycle", int'(owed_cnt), 1);
        chk(pulse_cnt - p0 == 1, "R8 one cycle completed", pulse_cnt - p0, 1);
        drain(1, "R8 remaining pulse");

        // R8 collision at the ceiling
        g = 0;
        while (owed_cnt != PMAX && g < 10 * IVL) begin
            step(1);
            g++;
        end
        p0 = pulse_cnt;
        step(IVL - LEN - 1);
        ref_gnt = 1'b1;
        step(LEN + 1);
        chk(owed_cnt == PMAX, "R8 collision at ceiling", int'(owed_cnt), PMAX);
        chk(pulse_cnt - p0 == 1, "R8 one cycle completed at ceiling", pulse_cnt - p0, 1);
        drain(PMAX, "R8 drain after ceiling collision");

        // R9 grant withdrawn during column setup
        align();
        ref_gnt = 1'b1;
        step(1);
        chk(!cas_n && ras_n, "R4 column strobe leads", {ras_n, cas_n}, 2'b10);
        ref_gnt = 1'b0;
        #1;
        chk(ras_n && cas_n, "R9 strobes released on grant loss", {ras_n, cas_n}, 2'b11);
        step(PRE + 2);
        chk(owed_cnt == 1 && ref_req, "R9 abandoned cycle not counted", int'(owed_cnt), 1);
        drain(1, "R9 retried after abandon");

        chk(v_gnt == 0, "R9 strobes idle without grant", v_gnt, 0);
        chk(v_req == 0, "R10 strobes idle without request", v_req, 0);
        chk(v_flt == 0, "R11 float during strobes", v_flt, 0);
        chk(mem_ready, "R3 ready held", int'(mem_ready), 1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", WD_CYC, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule